// File: doc/BRIEF.md
# Three-Level PWM Command Decoder

This block sits between the comparators that digitise a three-level PWM control pin and the sequencer that drives a high-side and a low-side power switch. On each clock it reads two flags: one saying the pin sits above the upper threshold, the other saying it sits below the lower threshold. From these it forms a registered drive command: HIGH (high-side switch requested on), LOW (low-side switch requested on) or OFF (both switches requested off). The command then passes to a downstream non-overlap sequencer.

Three rules shape the command. A mid-level input means shutdown, but only after it has persisted for a hold-off time; a shorter excursion is treated as a glitch and leaves the command unchanged. Once HIGH or LOW is accepted, it is kept for a minimum time before the opposite level is allowed to take over. An enable input, seen through a fixed propagation delay, and a supply lockout input both override everything and force OFF. All times are parameters counted in clock cycles.

The control is a three-state machine. Its states are ST_OFF, ST_LOW and ST_HIGH, and it has these transitions:
- OFF to HIGH on a high sample, and OFF to LOW on a low sample.
- HIGH to LOW on a low sample once the minimum-on timer has expired. LOW to HIGH on a high sample once the minimum-off timer has expired.
- HIGH or LOW to OFF when the mid-level hold-off has expired.
- Any state to OFF while lockout is active or the delayed enable is low.

Top module: `tristate_pwm_decoder`

## Requirements
- R1: The input level for a sample is high when only `above_hi` is 1, low when only `below_lo` is 1, and mid-level when both flags are 0 or both are 1.
- R2: `cmd` is encoded OFF=2'b00, LOW=2'b01, HIGH=2'b10. `hs_on` is 1 only in HIGH and `ls_on` is 1 only in LOW, so the two are never 1 together. A sample taken at a clock edge is reflected in the outputs right after that same edge.
- R3: `cmd` becomes OFF at the edge that takes the HOLDOFF_CYC-th consecutive mid-level sample. A shorter mid-level run keeps the previous command, and the next mid-level run counts again from zero.
- R4: After the edge that enters HIGH, low samples are ignored until HIGH has been held for MIN_ON_CYC cycles. The earliest transition to LOW is therefore the MIN_ON_CYC-th edge after entry.
- R5: After the edge that enters LOW, high samples are ignored until LOW has been held for MIN_OFF_CYC cycles. The earliest transition to HIGH is the MIN_OFF_CYC-th edge after entry.
- R6: `enable` reaches the state machine after EN_DLY_CYC clock edges, both when it rises and when it falls. A delayed enable of 0 forces OFF at the next edge.
- R7: A `lockout` value of 1 sampled at an edge forces OFF at that edge, even inside a minimum-time window. Once lockout is released, the next valid sample is accepted normally.
- R8: During reset and after it, `cmd` is OFF. From OFF, mid-level samples keep OFF; only a high or low sample, with enable effective and no lockout, leaves OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| above_hi | input | 1 | Comparator flag: input above upper threshold |
| below_lo | input | 1 | Comparator flag: input below lower threshold |
| enable | input | 1 | Active-high enable, delayed internally |
| lockout | input | 1 | Supply lockout active, forces OFF |
| cmd | output | 2 | Drive command (OFF/LOW/HIGH) |
| hs_on | output | 1 | High-side switch request |
| ls_on | output | 1 | Low-side switch request |

## Verification
The assertions assume the comparator flags, enable and lockout are synchronous to `clk` and hold steady across each edge; any two-flag combination is legal. The assertions make no assumption about how long a level lasts, so a one-cycle glitch is just as valid as a long run. The stimulus changes every input only on the falling clock edge. It mixes random level runs of 1 to 20 cycles, which straddle both the hold-off and the minimum times, with occasional enable flips and short lockout pulses. Directed sequences land exactly one cycle either side of each timing boundary.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

    typedef enum logic [1:0] {
        LVL_MID = 2'd0,
        LVL_LO  = 2'd1,
        LVL_HI  = 2'd2
    } lvl_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_LOW  = 2'b01,
        ST_HIGH = 2'b10
    } drv_state_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tpd_level_filter.sv
module tpd_level_filter
    import tpd_pkg::*;
#(
    parameter int HOLDOFF_CYC = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic above_hi,
    input  logic below_lo,
    output lvl_t lvl,
    output logic mid_expired
);
    localparam int RUN_W = (HOLDOFF_CYC > 2) ? $clog2(HOLDOFF_CYC) : 1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(HOLDOFF_CYC - 1);

    logic [RUN_W-1:0] run_q;
    logic             is_mid;

    always_comb begin
        if (above_hi && !below_lo) begin
            lvl = LVL_HI;
        end else if (below_lo && !above_hi) begin
            lvl = LVL_LO;
        end else begin
            lvl = LVL_MID;
        end
    end

    assign is_mid      = (lvl == LVL_MID);
    assign mid_expired = is_mid && (run_q == RUN_LAST);

    // run_q counts mid samples seen before the current one, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!is_mid) begin
            run_q <= '0;
        end else if (run_q != RUN_LAST) begin
            run_q <= run_q + 1'b1;
        end
    end

    assert_run_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_LAST);

    assert_expire_only_mid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mid_expired |-> (above_hi == below_lo));

    assert_run_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (above_hi != below_lo) |=> (run_q == '0));

endmodule

// File: rtl/tpd_en_delay.sv
module tpd_en_delay #(
    parameter int EN_DLY_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_in,
    output logic en_eff
);
    generate
        if (EN_DLY_CYC == 0) begin : g_direct
            assign en_eff = en_in;
        end else begin : g_pipe
            logic [EN_DLY_CYC-1:0] pipe_q;
            if (EN_DLY_CYC == 1) begin : g_one
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe_q <= '0;
                    else        pipe_q <= en_in;
                end
            end else begin : g_many
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe_q <= '0;
                    else        pipe_q <= {pipe_q[EN_DLY_CYC-2:0], en_in};
                end
            end
            assign en_eff = pipe_q[EN_DLY_CYC-1];

            assert_first_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (pipe_q[0] == $past(en_in)));
        end
    endgenerate

endmodule

// File: rtl/tpd_drive_fsm.sv
module tpd_drive_fsm
    import tpd_pkg::*;
#(
    parameter int MIN_ON_CYC  = 7,
    parameter int MIN_OFF_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  lvl_t       lvl,
    input  logic       mid_expired,
    input  logic       en_eff,
    input  logic       lockout,
    output logic [1:0] cmd,
    output logic       hs_on,
    output logic       ls_on
);
    localparam int HOLD_MAX = max_int(max_int(MIN_ON_CYC, MIN_OFF_CYC), 2);
    localparam int HOLD_W   = $clog2(HOLD_MAX);
    localparam logic [HOLD_W-1:0] ON_LOAD  = HOLD_W'(MIN_ON_CYC  - 1);
    localparam logic [HOLD_W-1:0] OFF_LOAD = HOLD_W'(MIN_OFF_CYC - 1);

    drv_state_t        state_q, state_d;
    logic [HOLD_W-1:0] hold_q, hold_d;
    logic              force_off;

    assign force_off = lockout || !en_eff;

    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        if (force_off) begin
            state_d = ST_OFF;
            hold_d  = '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    if (lvl == LVL_HI) begin
                        state_d = ST_HIGH;
                        hold_d  = ON_LOAD;
                    end else if (lvl == LVL_LO) begin
                        state_d = ST_LOW;
                        hold_d  = OFF_LOAD;
                    end
                end
                ST_HIGH: begin
                    if (mid_expired) begin
                        state_d = ST_OFF;
                        hold_d  = '0;
                    end else if (hold_q != '0) begin
                        hold_d = hold_q - 1'b1;
                    end else if (lvl == LVL_LO) begin
                        state_d = ST_LOW;
                        hold_d  = OFF_LOAD;
                    end
                end
                ST_LOW: begin
                    if (mid_expired) begin
                        state_d = ST_OFF;
                        hold_d  = '0;
                    end else if (hold_q != '0) begin
                        hold_d = hold_q - 1'b1;
                    end else if (lvl == LVL_HI) begin
                        state_d = ST_HIGH;
                        hold_d  = ON_LOAD;
                    end
                end
                default: begin
                    state_d = ST_OFF;
                    hold_d  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
        end
    end

    always_comb begin
        cmd   = 2'b00;
        hs_on = 1'b0;
        ls_on = 1'b0;
        unique case (state_q)
            ST_HIGH: begin
                cmd   = 2'b10;
                hs_on = 1'b1;
            end
            ST_LOW: begin
                cmd   = 2'b01;
                ls_on = 1'b1;
            end
            default: begin
                cmd = 2'b00;
            end
        endcase
    end

    assert_lockout_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> (state_q == ST_OFF));

    assert_enable_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_eff |=> (state_q == ST_OFF));

    assert_min_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && hold_q != '0 && !force_off && !mid_expired)
            |=> (state_q == ST_HIGH));

    assert_min_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW && hold_q != '0 && !force_off && !mid_expired)
            |=> (state_q == ST_LOW));

    assert_tri_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == LVL_MID && !mid_expired && !force_off)
            |=> (state_q == $past(state_q)));

    assert_off_needs_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && lvl == LVL_MID) |=> (state_q == ST_OFF));

endmodule

// File: rtl/tristate_pwm_decoder.sv
module tristate_pwm_decoder
    import tpd_pkg::*;
#(
    parameter int EN_DLY_CYC  = 5,
    parameter int MIN_ON_CYC  = 7,
    parameter int MIN_OFF_CYC = 8,
    parameter int HOLDOFF_CYC = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       above_hi,
    input  logic       below_lo,
    input  logic       enable,
    input  logic       lockout,
    output logic [1:0] cmd,
    output logic       hs_on,
    output logic       ls_on
);
    lvl_t lvl;
    logic mid_expired;
    logic en_eff;

    tpd_level_filter #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_level (
        .clk         (clk),
        .rst_n       (rst_n),
        .above_hi    (above_hi),
        .below_lo    (below_lo),
        .lvl         (lvl),
        .mid_expired (mid_expired)
    );

    tpd_en_delay #(.EN_DLY_CYC(EN_DLY_CYC)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_in  (enable),
        .en_eff (en_eff)
    );

    tpd_drive_fsm #(
        .MIN_ON_CYC  (MIN_ON_CYC),
        .MIN_OFF_CYC (MIN_OFF_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl         (lvl),
        .mid_expired (mid_expired),
        .en_eff      (en_eff),
        .lockout     (lockout),
        .cmd         (cmd),
        .hs_on       (hs_on),
        .ls_on       (ls_on)
    );

    assert_gate_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on));

    assert_cmd_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != 2'b11);

endmodule

// File: tb/tristate_pwm_decoder_tb.sv
module tristate_pwm_decoder_tb;
    localparam int EN_DLY  = 5;
    localparam int MIN_ON  = 7;
    localparam int MIN_OFF = 8;
    localparam int HOLDOFF = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above_hi = 1'b0, below_lo = 1'b0, enable = 1'b0, lockout = 1'b0;
    logic [1:0] cmd;
    logic hs_on, ls_on;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    bit model_on = 1'b0;

    always #2 clk = ~clk;

    tristate_pwm_decoder #(
        .EN_DLY_CYC(EN_DLY), .MIN_ON_CYC(MIN_ON),
        .MIN_OFF_CYC(MIN_OFF), .HOLDOFF_CYC(HOLDOFF)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .above_hi(above_hi), .below_lo(below_lo),
        .enable(enable), .lockout(lockout), .cmd(cmd), .hs_on(hs_on), .ls_on(ls_on)
    );

    // expected-behaviour model: 0=OFF 1=LOW 2=HIGH
    int m_state = 0;
    int m_hold  = 0;
    int m_run   = 0;
    logic [EN_DLY-1:0] m_en = '0;

    function automatic int classify(input logic a, input logic b);
        if (a && !b) return 2;
        if (b && !a) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_hold = 0; m_run = 0; m_en = '0;
        end else begin
            int lv;
            bit expired;
            bit forced;
            lv = classify(above_hi, below_lo);
            expired = (lv == 0) && (m_run >= HOLDOFF - 1);
            forced = lockout || !m_en[EN_DLY-1];
            if (forced) begin
                m_state = 0; m_hold = 0;
            end else if (m_state == 0) begin
                if (lv == 2) begin m_state = 2; m_hold = MIN_ON - 1; end
                else if (lv == 1) begin m_state = 1; m_hold = MIN_OFF - 1; end
            end else if (expired) begin
                m_state = 0; m_hold = 0;
            end else if (m_hold > 0) begin
                m_hold = m_hold - 1;
            end else if (m_state == 2 && lv == 1) begin
                m_state = 1; m_hold = MIN_OFF - 1;
            end else if (m_state == 1 && lv == 2) begin
                m_state = 2; m_hold = MIN_ON - 1;
            end
            m_run = (lv == 0) ? ((m_run < HOLDOFF - 1) ? m_run + 1 : m_run) : 0;
            m_en  = {m_en[EN_DLY-2:0], enable};
        end
    end

    function automatic logic [1:0] code_of(input int s);
        return (s == 2) ? 2'b10 : (s == 1) ? 2'b01 : 2'b00;
    endfunction

    task automatic chk(input string tag, input int exp_s);
        logic [3:0] act, exp;
        act = {cmd, hs_on, ls_on};
        exp = {code_of(exp_s), exp_s == 2, exp_s == 1};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s: {cmd,hs,ls} actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle model comparison, R2 encoding and all timing rules
    always @(negedge clk) begin
        if (rst_n && model_on && !done) chk("R2 model", m_state);
    end

    task automatic set_lvl(input int l);
        above_hi = (l == 2) || (l == 3);
        below_lo = (l == 1) || (l == 3);
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_tests++;
        n_fail++;
        $display("[TB] FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int lvl_now;
        int left;
        int lk_left;
        void'($urandom(32'h5EED_0042));
        run(3);
        chk("R8 reset", 0);
        rst_n = 1'b1;
        model_on = 1'b1;
        enable = 1'b1;
        set_lvl(2);
        run(EN_DLY);
        chk("R6 enable rise delay", 0);
        run(1);
        chk("R6 enable reached", 2);
        // R4: minimum on time
        set_lvl(1);
        run(MIN_ON - 1);
        chk("R4 low ignored", 2);
        run(1);
        chk("R4 low accepted", 1);
        // R5: minimum off time
        set_lvl(2);
        run(MIN_OFF - 1);
        chk("R5 high ignored", 1);
        run(1);
        chk("R5 high accepted", 2);
        // R3: short mid run, then restart with both flags set (R1)
        set_lvl(0);
        run(HOLDOFF - 1);
        chk("R3 short mid keeps", 2);
        set_lvl(2);
        run(1);
        chk("R3 back high", 2);
        set_lvl(3);
        run(HOLDOFF - 1);
        chk("R1 both flags as mid, R3 restart", 2);
        run(1);
        chk("R3 holdoff expired", 0);
        // R8: mid from OFF stays OFF
        set_lvl(0);
        run(3);
        chk("R8 mid keeps off", 0);
        set_lvl(1);
        run(1);
        chk("R1 low level", 1);
        // R7: lockout overrides min time
        lockout = 1'b1;
        run(1);
        chk("R7 lockout forces off", 0);
        run(3);
        chk("R7 lockout held", 0);
        lockout = 1'b0;
        run(1);
        chk("R7 released", 1);
        // R6: enable fall and rise delays
        enable = 1'b0;
        run(EN_DLY);
        chk("R6 enable fall delay", 1);
        run(1);
        chk("R6 enable off", 0);
        enable = 1'b1;
        run(EN_DLY);
        chk("R6 still off", 0);
        run(1);
        chk("R6 re-enabled", 1);
        // random phase
        lvl_now = 0;
        left = 0;
        lk_left = 0;
        for (int c = 0; c < 4000; c++) begin
            if (left == 0) begin
                int r;
                r = $urandom % 8;
                lvl_now = (r < 3) ? 2 : (r < 6) ? 1 : (r == 6) ? 0 : 3;
                left = 1 + ($urandom % 20);
            end
            left--;
            set_lvl(lvl_now);
            if (($urandom % 64) == 0) enable = ~enable;
            if (lk_left > 0) begin
                lk_left--;
                lockout = (lk_left != 0);
            end else if (($urandom % 128) == 0) begin
                lk_left = 1 + ($urandom % 4);
                lockout = 1'b1;
            end
            run(1);
        end
        finish_up();
    end
endmodule